// File: doc/BRIEF.md
# Polyphase Resampling FIR Engine

This engine produces one output sample of an asynchronous sample rate converter per output-rate strobe. The rate-tracking loop provides three values with each strobe: a start address in the buffered input sample RAM, a start position on the filter's phase axis, and the step that position advances by for each input sample. The engine then runs one multiply-accumulate pass over both channels. It walks backwards through the sample RAM and forwards along a virtual prototype filter that has 2^20 phases per input period.

The prototype is held as a sparse coefficient table with 64 points per tap. A phase position `u` (tap bits above 20 phase bits) selects table point `u >> 14`. The low 14 bits linearly interpolate between that point and the next one. When upsampling, the rate loop passes a step of 2^20, so the pass covers exactly 64 taps. When decimating, it passes a smaller step. This widens the filter in time, which lowers its cutoff and lengthens the convolution by the rate ratio. A fixed cap bounds the length so that the reads stay inside the RAM window.

The result leaves on a valid/ready stream. Back-pressure is allowed: a result is held unchanged while `out_ready_i` is low, and the engine stays busy until the result is taken. The strobe has no back-pressure. A strobe that arrives while busy is dropped and counted.

Top module: `polyfir_engine`

## Requirements
- R1: After reset, `busy_o` is 0, `out_valid_o` is 0 and `overrun_cnt_o` is 0.
- R2: A strobe seen while not busy is accepted and `busy_o` is 1 from the next cycle. `busy_o` stays 1 until the clock edge at which the output handshake (`out_valid_o` and `out_ready_i` both 1) completes.
- R3: Tap i (from 0) reads RAM address `(ram_start_i - i) mod 2^9` and table address `u_i >> 14`, where `u_i = rom_start_i + i*step_i`. Read data is returned one cycle after the address (registered reads).
- R4: Taps continue while `u_i < 64*2^20`, capped at 496 taps. A step of 2^20 gives exactly 64 taps.
- R5: The table returns point k on `coef_lo_i` and point k+1 on `coef_hi_i` (0 when k+1 = 4096). The tap coefficient is `lo + floor((hi-lo)*f / 2^14)`, where f is `u_i mod 2^14`.
- R6: The left and right channels use the same coefficient at every tap.
- R7: Each channel output is `sat24(floor((sum(coef*sample) + 2^16) / 2^17))`, saturated to the range -8388608..8388607. The accumulator is 48 bits wide.
- R8: While `out_valid_o` is 1 and `out_ready_i` is 0, the outputs hold their values.
- R9: A strobe seen while busy, including in the handshake cycle, starts nothing and raises `overrun_cnt_o` by one. The counter saturates at 255.
- R10: Each accepted strobe yields exactly one output sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| strobe_i | input | 1 | Output-rate strobe, one cycle |
| ram_start_i | input | 9 | Newest sample address for tap 0 |
| rom_start_i | input | 20 | Phase position of tap 0 |
| step_i | input | 21 | Phase advance per input sample |
| busy_o | output | 1 | Convolution in progress or result pending |
| overrun_cnt_o | output | 8 | Saturating count of dropped strobes |
| ram_rd_o | output | 1 | Sample RAM read enable |
| ram_addr_o | output | 9 | Sample RAM read address |
| ram_left_i | input | 24 | Left sample, one cycle after address |
| ram_right_i | input | 24 | Right sample, one cycle after address |
| coef_addr_o | output | 12 | Coefficient table point address |
| coef_lo_i | input | 18 | Table point at address |
| coef_hi_i | input | 18 | Table point at address + 1 |
| out_valid_o | output | 1 | Output sample valid |
| out_ready_i | input | 1 | Consumer ready |
| out_left_o | output | 24 | Left output sample |
| out_right_o | output | 24 | Right output sample |

## Verification
A new strobe and the hand-off of the previous result can land in the same cycle. The bench provokes this by stalling the consumer until a result is valid, then raising `out_ready_i` and `strobe_i` together for one cycle. The outcome is judged correct if the result is taken exactly once, `busy_o` falls, the overrun count rises by one and no further result appears. A second case lands a strobe in the middle of a convolution. The delivered result must match the first request, and the drop must be counted.

// File: rtl/pf_pkg.sv
package pf_pkg;
  // Phase axis split: tap bits above the per-tap phase bits
  localparam int unsigned PF_PHASE_W = 20;
  // Output round/saturate result kind
  typedef enum logic [1:0] {
    PF_RS_PASS = 2'd0,
    PF_RS_HIGH = 2'd1,
    PF_RS_LOW  = 2'd2
  } pf_rs_kind_e;
endpackage

// File: rtl/pf_seq.sv
module pf_seq #(
  parameter int TAPS    = 64,
  parameter int PHASE_W = 20,
  parameter int PT_W    = 6,
  parameter int RAM_AW  = 9,
  parameter int MAX_LEN = 496
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic [RAM_AW-1:0]            ram_start_i,
  input  logic [PHASE_W-1:0]           rom_start_i,
  input  logic [PHASE_W:0]             step_i,
  output logic                         issue_v_o,
  output logic                         issue_last_o,
  output logic [RAM_AW-1:0]            ram_addr_o,
  output logic [$clog2(TAPS)+PT_W-1:0] coef_addr_o,
  output logic [PHASE_W-PT_W-1:0]      frac_o
);
  localparam int TAP_W   = $clog2(TAPS);
  localparam int U_W     = TAP_W + PHASE_W + 1;
  localparam int FRAC_W  = PHASE_W - PT_W;
  localparam int CADDR_W = TAP_W + PT_W;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam logic [U_W-1:0]   U_END    = U_W'(TAPS) << PHASE_W;
  localparam logic [LEN_W-1:0] LEN_LAST = LEN_W'(MAX_LEN - 1);

  logic               run_q;
  logic [U_W-1:0]     u_q, u_next;
  logic [RAM_AW-1:0]  addr_q;
  logic [PHASE_W:0]   step_q;
  logic [LEN_W-1:0]   cnt_q;
  logic               last;

  always_comb begin
    u_next = u_q + U_W'(step_q);
    last   = (u_next >= U_END) || (cnt_q == LEN_LAST);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      u_q    <= '0;
      addr_q <= '0;
      step_q <= '0;
      cnt_q  <= '0;
    end else if (start_i) begin
      run_q  <= 1'b1;
      u_q    <= U_W'(rom_start_i);
      addr_q <= ram_start_i;
      step_q <= step_i;
      cnt_q  <= '0;
    end else if (run_q) begin
      if (last) run_q <= 1'b0;
      u_q    <= u_next;
      addr_q <= addr_q - 1'b1;
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign issue_v_o    = run_q;
  assign issue_last_o = run_q && last;
  assign ram_addr_o   = addr_q;
  assign coef_addr_o  = u_q[FRAC_W +: CADDR_W];
  assign frac_o       = u_q[FRAC_W-1:0];

  // R3
  ram_walk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_v_o && !issue_last_o |=> issue_v_o && (ram_addr_o == $past(ram_addr_o) - 1'b1));

  // R4
  len_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q < LEN_W'(MAX_LEN)));

  // R4
  phase_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (u_q < U_END));
endmodule

// File: rtl/pf_coef.sv
module pf_coef #(
  parameter int COEF_W = 18,
  parameter int SAMP_W = 24,
  parameter int FRAC_W = 14
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     issue_v_i,
  input  logic                     issue_last_i,
  input  logic [FRAC_W-1:0]        frac_i,
  input  logic signed [COEF_W-1:0] coef_lo_i,
  input  logic signed [COEF_W-1:0] coef_hi_i,
  input  logic signed [SAMP_W-1:0] smp_l_i,
  input  logic signed [SAMP_W-1:0] smp_r_i,
  output logic                     v_o,
  output logic                     last_o,
  output logic signed [COEF_W-1:0] coef_o,
  output logic signed [SAMP_W-1:0] smp_l_o,
  output logic signed [SAMP_W-1:0] smp_r_o
);
  localparam int D_W = COEF_W + 1;
  localparam int P_W = D_W + FRAC_W + 1;

  logic              v1_q, last1_q;
  logic [FRAC_W-1:0] frac1_q;

  logic signed [D_W-1:0] diff;
  logic signed [P_W-1:0] prod, step_part, c_full;
  logic signed [COEF_W-1:0] c_new;

  always_comb begin
    diff      = D_W'(coef_hi_i) - D_W'(coef_lo_i);
    prod      = P_W'(diff) * $signed({1'b0, frac1_q});
    step_part = prod >>> FRAC_W;
    c_full    = P_W'(coef_lo_i) + step_part;
    c_new     = c_full[COEF_W-1:0];
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      v1_q    <= 1'b0;
      last1_q <= 1'b0;
      frac1_q <= '0;
      v_o     <= 1'b0;
      last_o  <= 1'b0;
      coef_o  <= '0;
      smp_l_o <= '0;
      smp_r_o <= '0;
    end else begin
      v1_q    <= issue_v_i;
      last1_q <= issue_last_i;
      frac1_q <= frac_i;
      v_o     <= v1_q;
      last_o  <= v1_q && last1_q;
      if (v1_q) begin
        coef_o  <= c_new;
        smp_l_o <= smp_l_i;
        smp_r_o <= smp_r_i;
      end
    end
  end

  // R5
  interp_fit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v1_q |-> (c_full[P_W-1:COEF_W-1] == '0) || (&c_full[P_W-1:COEF_W-1]));

  // R5
  interp_span_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v1_q |-> ((coef_lo_i <= coef_hi_i) ? (c_new >= coef_lo_i && c_new <= coef_hi_i)
                                       : (c_new <= coef_lo_i && c_new >= coef_hi_i)));
endmodule

// File: rtl/pf_mac.sv
module pf_mac
  import pf_pkg::*;
#(
  parameter int COEF_W = 18,
  parameter int SAMP_W = 24,
  parameter int ACC_W  = 48
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic                     v_i,
  input  logic                     last_i,
  input  logic signed [COEF_W-1:0] coef_i,
  input  logic signed [SAMP_W-1:0] smp_l_i,
  input  logic signed [SAMP_W-1:0] smp_r_i,
  input  logic                     out_ready_i,
  output logic                     out_valid_o,
  output logic signed [SAMP_W-1:0] out_l_o,
  output logic signed [SAMP_W-1:0] out_r_o
);
  localparam int M_W   = COEF_W + SAMP_W;
  localparam int R_W   = ACC_W + 1;
  localparam int SHIFT = COEF_W - 1;
  localparam logic signed [R_W-1:0] SMAX = R_W'((64'sd1 <<< (SAMP_W - 1)) - 64'sd1);
  localparam logic signed [R_W-1:0] SMIN = -SMAX - R_W'(1);
  localparam logic signed [R_W-1:0] HALF = R_W'(64'sd1 <<< (SHIFT - 1));

  logic signed [ACC_W-1:0] acc_l_q, acc_r_q;
  logic signed [M_W-1:0]   mul_l, mul_r;
  logic                    fin_q;

  function automatic logic signed [SAMP_W-1:0] round_sat(input logic signed [ACC_W-1:0] a);
    logic signed [R_W-1:0] s, q;
    pf_rs_kind_e k;
    s = R_W'(a) + HALF;
    q = s >>> SHIFT;
    if (q > SMAX)      k = PF_RS_HIGH;
    else if (q < SMIN) k = PF_RS_LOW;
    else               k = PF_RS_PASS;
    case (k)
      PF_RS_HIGH: round_sat = SMAX[SAMP_W-1:0];
      PF_RS_LOW:  round_sat = SMIN[SAMP_W-1:0];
      default:    round_sat = q[SAMP_W-1:0];
    endcase
  endfunction

  always_comb begin
    mul_l = M_W'(coef_i) * M_W'(smp_l_i);
    mul_r = M_W'(coef_i) * M_W'(smp_r_i);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      acc_l_q     <= '0;
      acc_r_q     <= '0;
      fin_q       <= 1'b0;
      out_valid_o <= 1'b0;
      out_l_o     <= '0;
      out_r_o     <= '0;
    end else begin
      if (clear_i) begin
        acc_l_q <= '0;
        acc_r_q <= '0;
      end else if (v_i) begin
        acc_l_q <= acc_l_q + ACC_W'(mul_l);
        acc_r_q <= acc_r_q + ACC_W'(mul_r);
      end
      fin_q <= v_i && last_i;
      if (fin_q) begin
        out_valid_o <= 1'b1;
        out_l_o     <= round_sat(acc_l_q);
        out_r_o     <= round_sat(acc_r_q);
      end else if (out_valid_o && out_ready_i) begin
        out_valid_o <= 1'b0;
      end
    end
  end

  // R8
  hold_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o);

  // R8
  hold_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> $stable(out_l_o) && $stable(out_r_o));

  // R10
  no_mac_while_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_i |-> !out_valid_o);
endmodule

// File: rtl/polyfir_engine.sv
module polyfir_engine #(
  parameter int TAPS    = 64,
  parameter int PHASE_W = 20,
  parameter int PT_W    = 6,
  parameter int SAMP_W  = 24,
  parameter int COEF_W  = 18,
  parameter int ACC_W   = 48,
  parameter int RAM_AW  = 9,
  parameter int MAX_LEN = 496,
  parameter int OVR_W   = 8
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                strobe_i,
  input  logic [RAM_AW-1:0]                   ram_start_i,
  input  logic [PHASE_W-1:0]                  rom_start_i,
  input  logic [PHASE_W:0]                    step_i,
  output logic                                busy_o,
  output logic [OVR_W-1:0]                    overrun_cnt_o,
  output logic                                ram_rd_o,
  output logic [RAM_AW-1:0]                   ram_addr_o,
  input  logic [SAMP_W-1:0]                   ram_left_i,
  input  logic [SAMP_W-1:0]                   ram_right_i,
  output logic [$clog2(TAPS)+PT_W-1:0]        coef_addr_o,
  input  logic [COEF_W-1:0]                   coef_lo_i,
  input  logic [COEF_W-1:0]                   coef_hi_i,
  output logic                                out_valid_o,
  input  logic                                out_ready_i,
  output logic [SAMP_W-1:0]                   out_left_o,
  output logic [SAMP_W-1:0]                   out_right_o
);
  localparam int FRAC_W = PHASE_W - PT_W;

  logic busy_q, accept, handoff;
  logic [OVR_W-1:0] ovr_q;

  logic                     iss_v, iss_last;
  logic [FRAC_W-1:0]        iss_frac;
  logic                     m_v, m_last;
  logic signed [COEF_W-1:0] m_coef;
  logic signed [SAMP_W-1:0] m_l, m_r, o_l, o_r;

  assign accept  = strobe_i && !busy_q;
  assign handoff = out_valid_o && out_ready_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ovr_q  <= '0;
    end else begin
      if (accept)       busy_q <= 1'b1;
      else if (handoff) busy_q <= 1'b0;
      if (strobe_i && busy_q && !(&ovr_q)) ovr_q <= ovr_q + 1'b1;
    end
  end

  pf_seq #(
    .TAPS(TAPS), .PHASE_W(PHASE_W), .PT_W(PT_W), .RAM_AW(RAM_AW), .MAX_LEN(MAX_LEN)
  ) seq_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(accept),
    .ram_start_i(ram_start_i), .rom_start_i(rom_start_i), .step_i(step_i),
    .issue_v_o(iss_v), .issue_last_o(iss_last), .ram_addr_o(ram_addr_o),
    .coef_addr_o(coef_addr_o), .frac_o(iss_frac)
  );

  pf_coef #(
    .COEF_W(COEF_W), .SAMP_W(SAMP_W), .FRAC_W(FRAC_W)
  ) coef_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .issue_v_i(iss_v), .issue_last_i(iss_last),
    .frac_i(iss_frac), .coef_lo_i(coef_lo_i), .coef_hi_i(coef_hi_i),
    .smp_l_i(ram_left_i), .smp_r_i(ram_right_i),
    .v_o(m_v), .last_o(m_last), .coef_o(m_coef), .smp_l_o(m_l), .smp_r_o(m_r)
  );

  pf_mac #(
    .COEF_W(COEF_W), .SAMP_W(SAMP_W), .ACC_W(ACC_W)
  ) mac_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(accept), .v_i(m_v), .last_i(m_last),
    .coef_i(m_coef), .smp_l_i(m_l), .smp_r_i(m_r), .out_ready_i(out_ready_i),
    .out_valid_o(out_valid_o), .out_l_o(o_l), .out_r_o(o_r)
  );

  assign busy_o        = busy_q;
  assign overrun_cnt_o = ovr_q;
  assign ram_rd_o      = iss_v;
  assign out_left_o    = o_l;
  assign out_right_o   = o_r;

  // R2
  busy_covers_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> busy_q);

  // R2
  busy_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && !busy_q |=> busy_q && !out_valid_o);

  // R9
  overrun_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && busy_q |=> (ovr_q == $past(ovr_q) + 1'b1) || (&ovr_q));

  // R9
  overrun_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(strobe_i && busy_q) |=> $stable(ovr_q));

  // R3
  no_read_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_rd_o |-> busy_q);
endmodule

// File: tb/polyfir_engine_tb_top.sv
module polyfir_engine_tb_top;
  localparam int SW = 24, CW = 18, AW = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic strobe = 1'b0, out_ready = 1'b1;
  logic [AW-1:0] ram_start = '0;
  logic [19:0] rom_start = '0;
  logic [20:0] step = '0;
  logic busy, ram_rd, out_valid;
  logic [7:0] ovr;
  logic [AW-1:0] ram_addr;
  logic [SW-1:0] ram_l, ram_r, out_l, out_r;
  logic [11:0] coef_addr;
  logic [CW-1:0] c_lo, c_hi;

  int mem_l [512];
  int mem_r [512];
  int coef_mode = 0;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  longint exp_l_q[$];
  longint exp_r_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  polyfir_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .ram_start_i(ram_start),
    .rom_start_i(rom_start), .step_i(step), .busy_o(busy), .overrun_cnt_o(ovr),
    .ram_rd_o(ram_rd), .ram_addr_o(ram_addr), .ram_left_i(ram_l), .ram_right_i(ram_r),
    .coef_addr_o(coef_addr), .coef_lo_i(c_lo), .coef_hi_i(c_hi),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_left_o(out_l), .out_right_o(out_r)
  );

  function automatic longint cpt(int k);
    if (k >= 4096) return 0;
    if (coef_mode == 0) return longint'(((k * 73 + 11) % 4001) - 2000) * 30;
    return 131071;
  endfunction

  function automatic longint coef_at(longint u);
    longint a, b, f;
    a = cpt(int'(u >> 14));
    b = cpt(int'(u >> 14) + 1);
    f = u & 16383;
    return a + (((b - a) * f) >>> 14);
  endfunction

  function automatic longint sat24(longint acc);
    longint q;
    q = (acc + 65536) >>> 17;
    if (q > 8388607) return 8388607;
    if (q < -8388608) return -8388608;
    return q;
  endfunction

  // Bench-side table and sample RAM with registered reads
  always @(posedge clk) begin
    ram_l <= SW'(mem_l[ram_addr]);
    ram_r <= SW'(mem_r[ram_addr]);
    c_lo  <= CW'(cpt(int'(coef_addr)));
    c_hi  <= CW'(cpt(int'(coef_addr) + 1));
  end

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Expected result per R3, R4, R5, R6, R7
  task automatic push_expect(int rs, int ro, int st, string tag);
    longint al = 0, ar = 0, u, c;
    int a;
    for (int i = 0; i < 496; i++) begin
      u = longint'(ro) + longint'(i) * longint'(st);
      if (u >= (64 << 20)) break;
      c = coef_at(u);
      a = (rs - i) & 511;
      al += c * longint'(mem_l[a]);
      ar += c * longint'(mem_r[a]);
    end
    exp_l_q.push_back(sat24(al));
    exp_r_q.push_back(sat24(ar));
    tag_q.push_back(tag);
  endtask

  task automatic pulse(int rs, int ro, int st);
    ram_start = AW'(rs);
    rom_start = 20'(ro);
    step = 21'(st);
    strobe = 1'b1;
    tick();
    strobe = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) tick();
  endtask

  task automatic conv(int rs, int ro, int st, string tag);
    push_expect(rs, ro, st, tag);
    pulse(rs, ro, st);
    check(busy == 1'b1, "R2 busy after accept", longint'(busy), 1);
    wait_idle();
  endtask

  task automatic fill(int mode);
    for (int a = 0; a < 512; a++) begin
      if (mode == 0) begin
        mem_l[a] = ((a * 2654435 + 17) % 2000001) - 1000000;
        mem_r[a] = ((a * 40503 + 99) % 1500001) - 750000;
      end else if (mode == 1) begin
        mem_l[a] = 8388607;
        mem_r[a] = 8388607;
      end else begin
        mem_l[a] = -8388608;
        mem_r[a] = 8388607;
      end
    end
  endtask

  // Scoreboard monitor, R10 for each pop
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_l_q.size() == 0) begin
        check(1'b0, "R10 unexpected output", 1, 0);
      end else begin
        string t;
        longint el, er;
        t = tag_q.pop_front();
        el = exp_l_q.pop_front();
        er = exp_r_q.pop_front();
        check(longint'($signed(out_l)) == el, {"R7 left ", t}, longint'($signed(out_l)), el);
        check(longint'($signed(out_r)) == er, {"R6 right ", t}, longint'($signed(out_r)), er);
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      summary();
    end
  end

  initial begin
    logic [SW-1:0] held;
    fill(0);
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1
    check(busy == 0, "R1 busy", longint'(busy), 0);
    check(out_valid == 0, "R1 valid", longint'(out_valid), 0);
    check(ovr == 0, "R1 overrun", longint'(ovr), 0);

    // R3 R4 R5: upsampling, 64 taps
    conv(100, 0, 1 << 20, "R4 up phase0");
    conv(5, 'h3A5C7, 1 << 20, "R3 up wrap");
    conv(300, 'hFFFFF, 1 << 20, "R5 up last phase");
    // R4: decimation lengths
    conv(400, 'h41234, 1 << 19, "R4 dec2");
    conv(260, 'h12345, 'h55555, "R4 dec3");
    conv(480, 0, 1, "R4 cap496");
    conv(20, 'h7777, 'h180000, "R3 step1.5");
    // R7: saturation both ways
    coef_mode = 1; fill(1);
    conv(50, 0, 1 << 20, "R7 sat high");
    fill(2);
    conv(50, 0, 1 << 20, "R7 sat low");
    coef_mode = 0; fill(0);

    // R9: strobe mid-convolution is dropped and counted
    push_expect(77, 'h2222, 1 << 20, "R9 mid busy");
    pulse(77, 'h2222, 1 << 20);
    repeat (3) tick();
    pulse(200, 0, 1 << 19);
    check(ovr == 1, "R9 overrun mid", longint'(ovr), 1);
    wait_idle();
    tick();
    check(busy == 0 && exp_l_q.size() == 0, "R10 single result", longint'(exp_l_q.size()), 0);

    // R8 stall and R9 strobe in handshake cycle
    out_ready = 1'b0;
    push_expect(333, 'h9ABC, 1 << 20, "R8 stall");
    pulse(333, 'h9ABC, 1 << 20);
    while (!out_valid) tick();
    held = out_l;
    repeat (5) tick();
    check(out_valid == 1 && out_l == held, "R8 hold", longint'(out_l), longint'(held));
    check(busy == 1, "R2 busy while held", longint'(busy), 1);
    out_ready = 1'b1;
    pulse(10, 0, 1 << 20);
    check(busy == 0, "R2 busy cleared at handoff", longint'(busy), 0);
    check(ovr == 2, "R9 overrun at handoff", longint'(ovr), 2);
    repeat (3) tick();
    check(busy == 0 && out_valid == 0, "R9 no restart", longint'(busy), 0);

    // R9 saturation of the counter
    out_ready = 1'b0;
    push_expect(11, 'h1357, 1 << 20, "R9 sat run");
    pulse(11, 'h1357, 1 << 20);
    for (int n = 0; n < 260; n++) pulse(0, 0, 1 << 20);
    check(ovr == 255, "R9 overrun saturates", longint'(ovr), 255);
    out_ready = 1'b1;
    wait_idle();
    tick();
    check(exp_l_q.size() == 0, "R10 queue drained", longint'(exp_l_q.size()), 0);

    finished = 1;
    summary();
  end
endmodule